// File: doc/BRIEF.md
# Shared-Adder Integer ALU with Operation Decode

This block performs the integer arithmetic and logic step of a small 8-bit load/store processor. Each transaction carries two operands, a 2-bit operation class from the main controller and the 6-bit function field of the instruction. A two-level decoder turns the class and the function field into a 3-bit control code. That code steers a single shared adder, a bitwise logic unit and a result multiplexer. Add, subtract and set-on-less-than all use the one adder. For subtract and set-on-less-than, operand b is inverted and a carry of one is injected, so the adder computes a + ~b + 1. Set-on-less-than returns the sign bit of that difference.

Operands enter on a valid/ready stream. Results leave on a second valid/ready stream through one output register. A zero flag travels with each result and is meant for branch-if-equal decisions. Back-pressure works as follows. A transfer on either side happens only on a clock edge where valid and ready are both high. The block raises `in_ready` when its output register is empty or is being drained in that same cycle. While `out_valid` is high and `out_ready` is low, the result and the flag stay frozen.

Top module: `alu_unit`

## Requirements
- R1: Operation class 2'b00 yields (a + b) modulo 2^8, whatever the function field holds.
- R2: Operation class 2'b01 yields (a - b) modulo 2^8, computed as a + ~b + 1, whatever the function field holds.
- R3: Operation class 2'b10 decodes the function field as follows: 6'b100000 adds, 6'b100010 subtracts, 6'b100100 gives bitwise AND, and 6'b100101 gives bitwise OR.
- R4: Under class 2'b10, function 6'b101010 yields 1 when bit 7 of (a - b) modulo 2^8 is set, and 0 otherwise. Arithmetic overflow of the difference is not corrected.
- R5: Under class 2'b10, any function code not listed in R3 or R4 yields a result of zero. Class 2'b11 also yields a result of zero.
- R6: `out_zero` is 1 exactly when the 8-bit result it accompanies is all zeros.
- R7: An input transfer occurs when `in_valid` and `in_ready` are both high. `in_ready` is high when the output register is empty or when `out_ready` is high. Results leave in acceptance order. While `out_valid` is high and `out_ready` is low, `out_result` and `out_zero` hold their values.
- R8: While `rst_n` is low, and on the first cycle after it rises, `out_valid` is 0 and `in_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Operand transaction offered |
| in_ready | output | 1 | Block can take a transaction this cycle |
| in_class | input | 2 | Operation class from the controller |
| in_func | input | 6 | Function field of the instruction |
| in_a | input | 8 | Operand a |
| in_b | input | 8 | Operand b |
| out_valid | output | 1 | Result register holds a result |
| out_ready | input | 1 | Consumer takes the result this cycle |
| out_result | output | 8 | ALU result |
| out_zero | output | 1 | Result is all zeros |

## Verification
Two functions can land in the same cycle. The first pair is a subtract or a compare whose difference is zero, so the zero flag and the arithmetic result must agree. The second pair is a new operand pair accepted on the very edge where the held result is drained. The bench provokes the first case with equal operands under subtract and set-on-less-than, and with AND of disjoint bit patterns. It provokes the second by keeping `in_valid` high while toggling `out_ready` on a pseudo-random pattern. A behavioural queue model judges every cycle: it checks `out_valid` against its occupancy, and it checks the held result and flag against its head.

// File: rtl/alu_pkg.sv
package alu_pkg;
  localparam int CLASS_W = 2;
  localparam int FUNC_W  = 6;
  localparam int CODE_W  = 3;

  typedef enum logic [CODE_W-1:0] {
    CODE_AND  = 3'b000,
    CODE_OR   = 3'b001,
    CODE_ADD  = 3'b010,
    CODE_NONE = 3'b011,
    CODE_SUB  = 3'b110,
    CODE_SLT  = 3'b111
  } alu_code_e;

  typedef enum logic [CLASS_W-1:0] {
    CLS_ADD   = 2'b00,
    CLS_SUB   = 2'b01,
    CLS_FIELD = 2'b10,
    CLS_RSVD  = 2'b11
  } op_class_e;

  localparam logic [FUNC_W-1:0] FN_ADD = 6'b100000;
  localparam logic [FUNC_W-1:0] FN_SUB = 6'b100010;
  localparam logic [FUNC_W-1:0] FN_AND = 6'b100100;
  localparam logic [FUNC_W-1:0] FN_OR  = 6'b100101;
  localparam logic [FUNC_W-1:0] FN_SLT = 6'b101010;

  // Bit of the code that requests b inversion and carry injection.
  localparam int NEG_BIT = 2;
endpackage

// File: rtl/alu_ctl_decode.sv
module alu_ctl_decode
  import alu_pkg::*;
(
  input  logic [CLASS_W-1:0] op_class,
  input  logic [FUNC_W-1:0]  func,
  output alu_code_e          code
);
  alu_code_e field_code;

  // Second level: function field lookup.
  always_comb begin
    unique case (func)
      FN_ADD:  field_code = CODE_ADD;
      FN_SUB:  field_code = CODE_SUB;
      FN_AND:  field_code = CODE_AND;
      FN_OR:   field_code = CODE_OR;
      FN_SLT:  field_code = CODE_SLT;
      default: field_code = CODE_NONE;
    endcase
  end

  // First level: operation class overrides or defers.
  always_comb begin
    unique case (op_class_e'(op_class))
      CLS_ADD:   code = CODE_ADD;
      CLS_SUB:   code = CODE_SUB;
      CLS_FIELD: code = field_code;
      default:   code = CODE_NONE;
    endcase
  end
endmodule

// File: rtl/alu_core.sv
module alu_core
  import alu_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic [WIDTH-1:0] a,
  input  logic [WIDTH-1:0] b,
  input  alu_code_e        code,
  output logic [WIDTH-1:0] result,
  output logic             zero
);
  localparam int SUM_W = WIDTH + 1;

  logic             negate;
  logic [WIDTH-1:0] b_eff;
  logic [SUM_W-1:0] sum;
  logic [WIDTH-1:0] and_v;
  logic [WIDTH-1:0] or_v;
  logic [WIDTH-1:0] slt_v;

  assign negate = code[NEG_BIT];

  // Per-bit conditional inversion and logic unit.
  for (genvar i = 0; i < WIDTH; i++) begin : g_bit
    assign b_eff[i] = b[i] ^ negate;
    assign and_v[i] = a[i] & b[i];
    assign or_v[i]  = a[i] | b[i];
  end

  // The one shared adder: a + b, or a + ~b + 1.
  assign sum = {1'b0, a} + {1'b0, b_eff} + {{WIDTH{1'b0}}, negate};

  assign slt_v = {{(WIDTH-1){1'b0}}, sum[WIDTH-1]};

  always_comb begin
    unique case (code)
      CODE_AND:            result = and_v;
      CODE_OR:             result = or_v;
      CODE_ADD, CODE_SUB:  result = sum[WIDTH-1:0];
      CODE_SLT:            result = slt_v;
      default:             result = '0;
    endcase
  end

  assign zero = ~|result;
endmodule

// File: rtl/alu_out_stage.sv
module alu_out_stage #(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic             drain,
  input  logic [WIDTH-1:0] d_result,
  input  logic             d_zero,
  output logic             q_valid,
  output logic [WIDTH-1:0] q_result,
  output logic             q_zero
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      q_valid <= 1'b0;
    end else if (load) begin
      q_valid <= 1'b1;
    end else if (drain) begin
      q_valid <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      q_result <= '0;
      q_zero   <= 1'b1;
    end else if (load) begin
      q_result <= d_result;
      q_zero   <= d_zero;
    end
  end
endmodule

// File: rtl/alu_unit.sv
module alu_unit
  import alu_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [1:0]       in_class,
  input  logic [5:0]       in_func,
  input  logic [WIDTH-1:0] in_a,
  input  logic [WIDTH-1:0] in_b,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [WIDTH-1:0] out_result,
  output logic             out_zero
);
  alu_code_e        code;
  logic [WIDTH-1:0] comb_result;
  logic             comb_zero;
  logic             accept;
  logic             drain;

  assign drain    = out_valid & out_ready;
  assign in_ready = ~out_valid | out_ready;
  assign accept   = in_valid & in_ready;

  alu_ctl_decode u_dec (
    .op_class (in_class),
    .func     (in_func),
    .code     (code)
  );

  alu_core #(.WIDTH(WIDTH)) u_core (
    .a      (in_a),
    .b      (in_b),
    .code   (code),
    .result (comb_result),
    .zero   (comb_zero)
  );

  alu_out_stage #(.WIDTH(WIDTH)) u_out (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (accept),
    .drain    (drain),
    .d_result (comb_result),
    .d_zero   (comb_zero),
    .q_valid  (out_valid),
    .q_result (out_result),
    .q_zero   (out_zero)
  );
endmodule

// File: rtl/alu_unit_chk.sv
module alu_unit_chk #(
  parameter int WIDTH = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             in_valid,
  input logic             in_ready,
  input logic [1:0]       in_class,
  input logic [5:0]       in_func,
  input logic [WIDTH-1:0] in_a,
  input logic [WIDTH-1:0] in_b,
  input logic             out_valid,
  input logic             out_ready,
  input logic [WIDTH-1:0] out_result,
  input logic             out_zero
);
  logic fire;
  assign fire = in_valid & in_ready;

  AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_result) && $stable(out_zero)); // R7

  AST_STALL_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |-> !in_ready); // R7

  AST_ZERO_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> out_zero == (out_result == '0)); // R6

  AST_ADD_CLASS: assert property (@(posedge clk) disable iff (!rst_n)
    fire && in_class == 2'b00 |=> out_valid && out_result == WIDTH'($past(in_a) + $past(in_b))); // R1

  AST_SUB_CLASS: assert property (@(posedge clk) disable iff (!rst_n)
    fire && in_class == 2'b01 |=> out_valid && out_result == WIDTH'($past(in_a) - $past(in_b))); // R2

  AST_SLT_BINARY: assert property (@(posedge clk) disable iff (!rst_n)
    fire && in_class == 2'b10 && in_func == 6'b101010 |=> out_result <= WIDTH'(1)); // R4

  AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    fire && in_class == 2'b11 |=> out_result == '0 && out_zero); // R5

  AST_RESET_EMPTY: assert property (@(posedge clk)
    !rst_n |=> !out_valid); // R8
endmodule

bind alu_unit alu_unit_chk #(.WIDTH(WIDTH)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .in_valid   (in_valid),
  .in_ready   (in_ready),
  .in_class   (in_class),
  .in_func    (in_func),
  .in_a       (in_a),
  .in_b       (in_b),
  .out_valid  (out_valid),
  .out_ready  (out_ready),
  .out_result (out_result),
  .out_zero   (out_zero)
);

// File: tb/sim_alu_unit.sv
`timescale 1ns/1ps
module sim_alu_unit;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       in_valid = 1'b0;
  logic       in_ready;
  logic [1:0] in_class = '0;
  logic [5:0] in_func = '0;
  logic [7:0] in_a = '0;
  logic [7:0] in_b = '0;
  logic       out_valid;
  logic       out_ready = 1'b0;
  logic [7:0] out_result;
  logic       out_zero;

  int errors = 0;
  int checks = 0;
  int exp_q[$];
  string tag_q[$];
  int unsigned seed = 32'h1234_5678;
  bit accepted;

  always #4 clk = ~clk;

  alu_unit u0 (.*);

  function automatic int unsigned next_rand();
    seed = seed * 32'd1103515245 + 32'd12345;
    return seed >> 8;
  endfunction

  function automatic int ref_alu(int cls, int fn, int a, int b);
    int diff;
    diff = (a - b) & 255;
    case (cls)
      0: return (a + b) & 255;
      1: return diff;
      2: case (fn)
           32: return (a + b) & 255;
           34: return diff;
           36: return a & b;
           37: return a | b;
           42: return (diff >= 128) ? 1 : 0;
           default: return 0;
         endcase
      default: return 0;
    endcase
  endfunction

  function automatic string ref_tag(int cls, int fn);
    if (cls == 0) return "R1";
    if (cls == 1) return "R2";
    if (cls == 3) return "R5";
    if (fn == 32 || fn == 34 || fn == 36 || fn == 37) return "R3";
    if (fn == 42) return "R4";
    return "R5";
  endfunction

  task automatic check(bit ok, string req, string what, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic step(bit v, int cls, int fn, int a, int b, bit ordy);
    @(negedge clk);
    in_valid  = v;
    in_class  = cls[1:0];
    in_func   = fn[5:0];
    in_a      = a[7:0];
    in_b      = b[7:0];
    out_ready = ordy;
    #1;
    check(out_valid == (exp_q.size() > 0), "R7", "out_valid vs model", out_valid, exp_q.size());
    if (out_valid && exp_q.size() > 0) begin
      check(out_result == exp_q[0], tag_q[0], "result", out_result, exp_q[0]);
      check(out_zero == (exp_q[0] == 0), "R6", "zero flag", out_zero, exp_q[0] == 0);
    end
    if (out_valid && !out_ready)
      check(in_ready == 1'b0, "R7", "in_ready while stalled", in_ready, 0);
    if (out_valid && out_ready && exp_q.size() > 0) begin
      void'(exp_q.pop_front());
      void'(tag_q.pop_front());
    end
    accepted = in_valid && in_ready;
    if (accepted) begin
      exp_q.push_back(ref_alu(cls, fn, a, b));
      tag_q.push_back(ref_tag(cls, fn));
    end
  endtask

  task automatic send(int cls, int fn, int a, int b);
    accepted = 1'b0;
    while (!accepted) step(1'b1, cls, fn, a, b, (next_rand() % 3) != 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL R7 watchdog expired actual=%0d expected=%0d", 1, 0);
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    #1;
    check(out_valid == 1'b0, "R8", "out_valid in reset", out_valid, 0);
    check(in_ready == 1'b1, "R8", "in_ready in reset", in_ready, 1);
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    check(out_valid == 1'b0, "R8", "out_valid after reset", out_valid, 0);
    check(in_ready == 1'b1, "R8", "in_ready after reset", in_ready, 1);

    // Directed vectors
    send(0, 6'h3F, 200, 100);        // R1 wraps to 44
    send(1, 0, 5, 5);                // R2 and R6: zero
    send(1, 32, 3, 5);               // R2 0xFE, function ignored
    send(2, 32, 8'h7F, 8'h01);       // R3 add
    send(2, 34, 8'h10, 8'h20);       // R3 sub
    send(2, 36, 8'hF0, 8'h3C);       // R3 and -> 0x30
    send(2, 36, 8'hF0, 8'h0F);       // R3 and -> 0, R6
    send(2, 37, 8'hA0, 8'h05);       // R3 or
    send(2, 42, 8'h7F, 8'h80);       // R4 difference sign set -> 1
    send(2, 42, 8'h80, 8'h01);       // R4 difference 0x7F -> 0
    send(2, 42, 3, 3);               // R4 equal -> 0, R6
    send(2, 42, 2, 9);               // R4 -> 1
    send(2, 6'h3F, 8'hFF, 8'hFF);    // R5 unknown function
    send(2, 6'h21, 8'h12, 8'h34);    // R5 near-miss code
    send(3, 32, 8'h12, 8'h34);       // R5 reserved class

    // Stall: hold output with consumer not ready, offer new input
    step(1'b1, 0, 0, 1, 2, 1'b0);
    step(1'b1, 0, 0, 1, 2, 1'b0);
    step(1'b1, 0, 0, 1, 2, 1'b0);
    // Back-to-back: push and pop on the same edge
    for (int k = 0; k < 8; k++) step(1'b1, 2, 34, k, k, 1'b1);

    // Pseudo-random traffic with random back-pressure
    for (int n = 0; n < 3000; n++) begin
      int cls, fn, sel;
      cls = next_rand() % 4;
      sel = next_rand() % 7;
      case (sel)
        0: fn = 32; 1: fn = 34; 2: fn = 36; 3: fn = 37; 4: fn = 42;
        5: fn = next_rand() % 64;
        default: fn = 42;
      endcase
      step((next_rand() % 4) != 0, cls, fn, next_rand() % 256,
           (sel == 6) ? 0 : next_rand() % 256, (next_rand() % 3) != 0);
    end

    // Drain
    for (int k = 0; k < 4; k++) step(1'b0, 0, 0, 0, 0, 1'b1);
    check(exp_q.size() == 0, "R7", "model drained", exp_q.size(), 0);

    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule